// File: doc/BRIEF.md
# Frame-Periodic Strobe Sequencer

This block is a fixed-schedule timing controller. A free-running tick counter serves as the state number. It steps once per clock through a frame of 311 ticks, numbered 0 to 310, and then wraps to 0. At the intended 10 MHz clock, one tick is 100 ns and one frame is 31.1 us. A combinational lookup maps each tick number to four strobe levels. Those levels are captured in an output register, so each strobe is driven straight from a flop and cannot glitch while several counter bits change at once.

The lookup is indexed with the tick number the counter will hold after the next edge, not the current one. As a result, a registered strobe is high in exactly the cycles in which `tick_count` shows a scheduled tick, and the register adds no visible lag. The block is used as a repeating sequencer: reset starts a frame at tick 0, and after that the pattern repeats with no intervention.

Top module: `strobe_sequencer`

## Requirements
- R1: While `rst_n` is low, `tick_count` reads 0 and all four strobes read 0.
- R2: On each rising clock edge with `rst_n` high, `tick_count` goes up by 1. After tick 310 it goes to 0, so a frame is 311 cycles long and the count never exceeds 310.
- R3: `strobe_fast` is 1 exactly when `tick_count` is one of 5, 10, 15, …, 100 (every fifth tick from 5 to 100). Each pulse lasts one cycle.
- R4: `strobe_pair` is 1 exactly when `tick_count` is 5, 6, 210, 211, 280 or 281. These are three pulses, each two cycles long.
- R5: `strobe_wide` is 1 exactly when `tick_count` is in 8..12 or 150..154. These are two pulses, each five cycles long.
- R6: `frame_last` is 1 exactly when `tick_count` is 310, the last tick of the frame. It lasts one cycle.
- R7: All four strobes are flop outputs and line up with the count with no added delay. After reset is released, the first `strobe_fast` and `strobe_pair` pulses appear in the cycle that follows the fifth rising edge.
- R8: The strobe pattern is the same in every frame. Asserting reset in the middle of a frame immediately returns the count to 0 and the strobes to 0, and the next frame starts again from tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_fast | output | 1 | One-tick strobe every fifth tick from 5 to 100 |
| strobe_pair | output | 1 | Two-tick strobes at ticks 5, 210, 280 |
| strobe_wide | output | 1 | Five-tick strobes at ticks 8 and 150 |
| frame_last | output | 1 | One-tick marker at tick 310 |
| tick_count | output | 9 | Current tick number (state number), 0..310 |

## Verification
A corrupted counter state shows up on `tick_count` at the very next edge, as a skipped or repeated value or a value past 310. It also shows on the strobes as soon as the count reaches the next scheduled tick. A decode or alignment fault shows as a strobe one cycle early or late, or with the wrong width, at the first pulse of the frame (tick 5 or 8). A wrap fault surfaces within one frame, at the 310-to-0 transition and on `frame_last`. For that reason the bench compares every cycle of two whole frames and of a frame restarted by a mid-frame reset.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;

    typedef struct packed {
        logic fast;
        logic pair;
        logic wide;
        logic last;
    } strobe_set_t;

    localparam int FAST_FIRST = 5;
    localparam int FAST_STEP  = 5;
    localparam int FAST_FINAL = 100;

    localparam int PAIR_LEN   = 2;
    localparam int PAIR_NUM   = 3;
    localparam int PAIR_AT [PAIR_NUM] = '{5, 210, 280};

    localparam int WIDE_LEN   = 5;
    localparam int WIDE_NUM   = 2;
    localparam int WIDE_AT [WIDE_NUM] = '{8, 150};

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int FRAME_TICKS = 311,
    localparam int CNT_W = $clog2(FRAME_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    always_comb begin
        if (cnt_q == LAST) cnt_nxt = '0;
        else               cnt_nxt = cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // R2: wrap to zero after the final tick
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> (cnt_q == '0));
    // R2: single step everywhere else
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != LAST) |=> (cnt_q - $past(cnt_q) == ONE));
    // R2: never beyond the final tick
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import strobe_seq_pkg::*;
#(
    parameter int FRAME_TICKS = 311,
    localparam int CNT_W = $clog2(FRAME_TICKS)
) (
    input  logic [CNT_W-1:0] tick_idx,
    output strobe_set_t      lvl
);
    function automatic logic in_span(int t, int s, int len);
        return (t >= s) && (t < s + len);
    endfunction

    always_comb begin
        int t;
        t = int'(tick_idx);
        lvl.fast = (t >= FAST_FIRST) && (t <= FAST_FINAL) &&
                   (((t - FAST_FIRST) % FAST_STEP) == 0);
        lvl.pair = 1'b0;
        for (int i = 0; i < PAIR_NUM; i++)
            if (in_span(t, PAIR_AT[i], PAIR_LEN)) lvl.pair = 1'b1;
        lvl.wide = 1'b0;
        for (int i = 0; i < WIDE_NUM; i++)
            if (in_span(t, WIDE_AT[i], WIDE_LEN)) lvl.wide = 1'b1;
        lvl.last = (t == FRAME_TICKS - 1);
    end
endmodule

// File: rtl/strobe_outreg.sv
module strobe_outreg
    import strobe_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  strobe_set_t lvl_nxt,
    output strobe_set_t lvl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_nxt;
    end

    // R3: fast strobe is a single-cycle pulse
    p_fast_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.fast |=> !lvl_q.fast);
    // R4: pair strobe lasts at least two cycles
    p_pair_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q.pair && !$past(lvl_q.pair)) |=> lvl_q.pair);
    // R6: frame marker is a single-cycle pulse
    p_last_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.last |=> !lvl_q.last);
endmodule

// File: rtl/strobe_sequencer.sv
module strobe_sequencer
    import strobe_seq_pkg::*;
#(
    parameter int FRAME_TICKS = 311,
    localparam int CNT_W = $clog2(FRAME_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             strobe_fast,
    output logic             strobe_pair,
    output logic             strobe_wide,
    output logic             frame_last,
    output logic [CNT_W-1:0] tick_count
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    strobe_set_t      lvl_nxt;
    strobe_set_t      lvl_q;

    tick_counter #(.FRAME_TICKS(FRAME_TICKS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    // decode the upcoming tick so the register output aligns with cnt_q
    strobe_decode #(.FRAME_TICKS(FRAME_TICKS)) u_dec (
        .tick_idx (cnt_nxt),
        .lvl      (lvl_nxt)
    );

    strobe_outreg u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_nxt (lvl_nxt),
        .lvl_q   (lvl_q)
    );

    assign strobe_fast = lvl_q.fast;
    assign strobe_pair = lvl_q.pair;
    assign strobe_wide = lvl_q.wide;
    assign frame_last  = lvl_q.last;
    assign tick_count  = cnt_q;

    // R6: frame marker coincides with the last count value
    p_last_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.last |-> (cnt_q == LAST));
    // R7: pulses never show at count zero (register aligned, not lagging)
    p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> (lvl_q == '0));
endmodule

// File: tb/strobe_sequencer_tb.sv
module strobe_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_fast, s_pair, s_wide, s_last;
    logic [8:0] cnt;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    strobe_sequencer dut_i (
        .clk(clk), .rst_n(rst_n),
        .strobe_fast(s_fast), .strobe_pair(s_pair),
        .strobe_wide(s_wide), .frame_last(s_last),
        .tick_count(cnt)
    );

    function automatic logic [3:0] sched(int t);
        logic f, p, w, l;
        f = 1'b0;
        for (int k = 1; k <= 20; k++) if (t == 5 * k) f = 1'b1;
        p = (t == 5) || (t == 6) || (t == 210) || (t == 211) ||
            (t == 280) || (t == 281);
        w = (t >= 8 && t <= 12) || (t >= 150 && t <= 154);
        l = (t == 310);
        return {f, p, w, l};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_cycle(int t, string req);
        logic [3:0] e;
        e = sched(t);
        chk("R2 count", int'(cnt), t);
        chk({req, " R3 fast"}, int'(s_fast), int'(e[3]));
        chk({req, " R4 pair"}, int'(s_pair), int'(e[2]));
        chk({req, " R5 wide"}, int'(s_wide), int'(e[1]));
        chk({req, " R6 last"}, int'(s_last), int'(e[0]));
    endtask

    // R1: state while reset is held
    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        chk("R1 count", int'(cnt), 0);
        chk("R1 strobes", int'({s_fast, s_pair, s_wide, s_last}), 0);
    endtask

    // R2..R8: cycle-by-cycle sweep starting right at reset release
    task automatic t_sweep(int frames, string req);
        @(negedge clk);
        rst_n = 1'b1;
        chk_cycle(0, req);
        for (int k = 1; k <= frames * 311; k++) begin
            @(negedge clk);
            chk_cycle(k % 311, req);
        end
    endtask

    // R7: first pulses after the fifth edge
    task automatic t_first_pulse();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R7 early fast", int'(s_fast), 0);
        end
        @(negedge clk);
        chk("R7 fast on 5th edge", int'(s_fast), 1);
        chk("R7 pair on 5th edge", int'(s_pair), 1);
    endtask

    // R8: mid-frame reset while a wide pulse is active
    task automatic t_mid_reset();
        while (int'(cnt) != 151) @(negedge clk);
        chk("R8 wide before reset", int'(s_wide), 1);
        #2 rst_n = 1'b0;
        #1;
        chk("R8 count cleared", int'(cnt), 0);
        chk("R8 strobes cleared", int'({s_fast, s_pair, s_wide, s_last}), 0);
        repeat (2) @(negedge clk);
        chk("R1 held count", int'(cnt), 0);
        t_sweep(1, "R8");
    endtask

    initial begin
        t_reset_state();
        t_sweep(2, "R7");
        t_first_pulse();
        t_mid_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule